// File: doc/BRIEF.md
# Ternary Content-Addressable Match Array

This block holds a small set of ternary patterns and answers one question each cycle: which stored patterns does this key fit? Every entry keeps a value word, a care mask and a valid flag. A mask bit of 1 makes the key bit at that position count in the comparison. A mask bit of 0 turns that position into a wildcard that fits either key value. An entry with every mask bit set does an exact, binary lookup, for example turning a destination address into an output port number.

A search compares the key with all entries at the same time. One clock edge later the block returns three results together: a vector with one bit per entry that hit, a flag that is set when any entry hit, and the index of the lowest-numbered entry that hit. Software or a host engine programs the array through a single write port. That port loads one entry per cycle, or clears the valid flag of one entry. When a write and a search fall in the same cycle, the search compares against the contents the array held before that write.

Top module: `tcam_match_array`

## Requirements
- R1: After reset every entry is invalid, and `hitVec`, `hitAny`, `hitIdx` and `resultValid` are all 0. A search issued straight after reset finds no hit.
- R2: `resultValid` is 1 in exactly the cycle after a cycle with `srchEn` high. The results it qualifies are the ones for the key presented in that earlier cycle.
- R3: Where the care mask bit is 0, the entry matches either key value at that position. A 5-bit pattern 10XX0 (value 10000, care 11001, upper care bits 1 and upper value bits 0) hits for keys 10000, 10010, 10100 and 10110.
- R4: Where the care mask bit is 1, the key bit must equal the stored bit. The 10XX0 pattern misses every key outside the four listed in R3, and an entry whose care mask is all ones hits only its exact value.
- R5: Every matching entry sets its own bit in `hitVec` (bit i for entry i), so several bits can be set at once.
- R6: `hitAny` is 1 exactly when `hitVec` is non-zero. `hitIdx` is the lowest index i with `hitVec[i]` set.
- R7: An entry whose valid flag is 0 never hits, even when its care mask is all zeros. A write with `wrValid`=0 clears the flag.
- R8: A write and a search in the same cycle: the search sees the contents from before the write, and the next search sees the new contents.
- R9: When nothing hits, `hitVec` is 0, `hitAny` is 0 and `hitIdx` is 0.
- R10: In cycles where `resultValid` is 0, `hitVec`, `hitAny` and `hitIdx` keep their last values.
- R11: On a write, the stored value bits are cleared wherever the care bit is 0. Ones written into don't-care positions therefore do not stop a match: value 0xFF with care 0x0F hits key 0x0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one entry |
| wrIdx | input | IDX_W | Entry selected by the write |
| wrValid | input | 1 | 1 loads the entry and marks it valid, 0 invalidates it |
| wrValue | input | KEY_W | Value word to store |
| wrCare | input | KEY_W | Care mask, 1 = bit compared, 0 = don't care |
| srchEn | input | 1 | Start a search with srchKey |
| srchKey | input | KEY_W | Search key |
| hitVec | output | ENTRIES | One bit per entry that matched |
| hitAny | output | 1 | At least one entry matched |
| hitIdx | output | IDX_W | Lowest matching index, 0 when there is no hit |
| resultValid | output | 1 | Result outputs belong to the search of the previous cycle |

## Verification
The checker watches every cycle for the relations between the outputs. The index it reports must point at a set bit of the vector, and no set bit may lie below that index. The flag must agree with the vector. An empty result must carry index 0. `resultValid` must follow `srchEn` with a one-cycle delay, and the outputs must hold while no result is due. None of these relations says whether the right entries hit, so the scoreboard scenarios cover that part. They cover the wildcard pattern and its missing keys, exact entries, several hits at once, invalidated wildcard entries, value bits cleared under the mask, and the ordering of a write and a search in the same cycle.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic doWrite;   // update the selected entry
    logic setValid;  // 1 = program, 0 = invalidate
    logic doSearch;  // capture the compare results
  } tcamStrobe_t;
endpackage

// File: rtl/tcam_ctrl.sv
module tcam_ctrl
  import tcam_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic               wrValid,
  input  logic               srchEn,
  output tcamStrobe_t        strobe,
  output logic [ENTRIES-1:0] rowSel,
  output logic               resultValid
);
  always_comb begin
    strobe.doWrite  = wrEn;
    strobe.setValid = wrValid;
    strobe.doSearch = srchEn;
  end

  // one-hot row select; an index past the last entry selects nothing
  for (genvar i = 0; i < ENTRIES; i++) begin : g_sel
    assign rowSel[i] = wrEn && (wrIdx == IDX_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) resultValid <= 1'b0;
    else        resultValid <= srchEn;
  end
endmodule

// File: rtl/tcam_datapath.sv
module tcam_datapath
  import tcam_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  tcamStrobe_t        strobe,
  input  logic [ENTRIES-1:0] rowSel,
  input  logic [KEY_W-1:0]   wrValue,
  input  logic [KEY_W-1:0]   wrCare,
  input  logic [KEY_W-1:0]   srchKey,
  output logic [ENTRIES-1:0] hitVec,
  output logic               hitAny,
  output logic [IDX_W-1:0]   hitIdx
);
  logic [ENTRIES-1:0] matchNow;
  logic [IDX_W-1:0]   firstIdx;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_row
    logic [KEY_W-1:0] rowValue;
    logic [KEY_W-1:0] rowCare;
    logic             rowOk;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rowValue <= '0;
        rowCare  <= '0;
        rowOk    <= 1'b0;
      end else if (strobe.doWrite && rowSel[i]) begin
        rowOk <= strobe.setValid;
        if (strobe.setValid) begin
          rowValue <= wrValue & wrCare;
          rowCare  <= wrCare;
        end
      end
    end

    // compares against the contents held before this edge
    assign matchNow[i] = rowOk && ((srchKey & rowCare) == rowValue);
  end

  // lowest set bit wins; scan from the top so lower indices override
  always_comb begin
    firstIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchNow[i]) firstIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hitVec <= '0;
      hitAny <= 1'b0;
      hitIdx <= '0;
    end else if (strobe.doSearch) begin
      hitVec <= matchNow;
      hitAny <= |matchNow;
      hitIdx <= firstIdx;
    end
  end
endmodule

// File: rtl/tcam_match_array.sv
module tcam_match_array
  import tcam_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int KEY_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic               wrValid,
  input  logic [KEY_W-1:0]   wrValue,
  input  logic [KEY_W-1:0]   wrCare,
  input  logic               srchEn,
  input  logic [KEY_W-1:0]   srchKey,
  output logic [ENTRIES-1:0] hitVec,
  output logic               hitAny,
  output logic [IDX_W-1:0]   hitIdx,
  output logic               resultValid
);
  tcamStrobe_t        strobe;
  logic [ENTRIES-1:0] rowSel;

  tcam_ctrl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrValid(wrValid), .srchEn(srchEn), .strobe(strobe),
    .rowSel(rowSel), .resultValid(resultValid)
  );

  tcam_datapath #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) uData (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rowSel(rowSel),
    .wrValue(wrValue), .wrCare(wrCare), .srchKey(srchKey),
    .hitVec(hitVec), .hitAny(hitAny), .hitIdx(hitIdx)
  );
endmodule

// File: rtl/tcam_checker.sv
module tcam_checker #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               srchEn,
  input logic               resultValid,
  input logic [ENTRIES-1:0] hitVec,
  input logic               hitAny,
  input logic [IDX_W-1:0]   hitIdx
);
  logic [ENTRIES-1:0] belowIdx;
  assign belowIdx = (ENTRIES'(1) << hitIdx) - ENTRIES'(1);

  AST_VALID_AFTER_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    srchEn |=> resultValid); // R2
  AST_NO_VALID_WITHOUT_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    !srchEn |=> !resultValid); // R2
  AST_ANY_AGREES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    resultValid |-> (hitAny == (hitVec != '0))); // R6
  AST_IDX_POINTS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (resultValid && hitAny) |-> hitVec[hitIdx]); // R6
  AST_IDX_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (resultValid && hitAny) |-> ((hitVec & belowIdx) == '0)); // R6
  AST_EMPTY_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (resultValid && !hitAny) |-> (hitIdx == '0 && hitVec == '0)); // R9
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !resultValid |-> ($stable(hitVec) && $stable(hitAny) && $stable(hitIdx))); // R10
endmodule

bind tcam_match_array tcam_checker #(.ENTRIES(ENTRIES)) uChk (
  .clk(clk), .rst_n(rst_n), .srchEn(srchEn), .resultValid(resultValid),
  .hitVec(hitVec), .hitAny(hitAny), .hitIdx(hitIdx)
);

// File: tb/sim_tcam_match_array.sv
module sim_tcam_match_array;
  localparam int ENTRIES = 8;
  localparam int KEY_W   = 8;
  localparam int IDX_W   = $clog2(ENTRIES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0, wrValid = 1'b0, srchEn = 1'b0;
  logic [IDX_W-1:0] wrIdx = '0;
  logic [KEY_W-1:0] wrValue = '0, wrCare = '0, srchKey = '0;
  logic [ENTRIES-1:0] hitVec;
  logic hitAny, resultValid;
  logic [IDX_W-1:0] hitIdx;

  always #10 clk = ~clk; // 50 MHz

  tcam_match_array #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrIdx(wrIdx), .wrValid(wrValid),
    .wrValue(wrValue), .wrCare(wrCare), .srchEn(srchEn), .srchKey(srchKey),
    .hitVec(hitVec), .hitAny(hitAny), .hitIdx(hitIdx), .resultValid(resultValid)
  );

  typedef struct {
    logic [ENTRIES-1:0] vec;
    logic               any;
    logic [IDX_W-1:0]   idx;
    string              tag;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t lastExp;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // reference contents kept by the bench
  logic [KEY_W-1:0] mVal [ENTRIES];
  logic [KEY_W-1:0] mCare[ENTRIES];
  logic             mOk  [ENTRIES];

  function automatic expItem_t predict(input logic [KEY_W-1:0] key, input string tag);
    expItem_t e;
    e.vec = '0; e.any = 1'b0; e.idx = '0; e.tag = tag;
    for (int i = 0; i < ENTRIES; i++) begin
      logic fits;
      fits = 1'b1;
      for (int b = 0; b < KEY_W; b++)
        if (mCare[i][b] && (key[b] != mVal[i][b])) fits = 1'b0;
      if (mOk[i] && fits) begin
        if (!e.any) e.idx = IDX_W'(i);
        e.vec[i] = 1'b1;
        e.any = 1'b1;
      end
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive a write and optionally a search in the same cycle
  task automatic cycle(input bit doWr, input int idx, input bit ok,
                       input logic [KEY_W-1:0] val, input logic [KEY_W-1:0] care,
                       input bit doSr, input logic [KEY_W-1:0] key, input string tag);
    @(negedge clk);
    if (doSr) expQ.push_back(predict(key, tag)); // old contents (R8)
    wrEn = doWr; wrIdx = IDX_W'(idx); wrValid = ok; wrValue = val; wrCare = care;
    srchEn = doSr; srchKey = key;
    @(posedge clk);
    if (doWr && idx < ENTRIES) begin
      mOk[idx] = ok;
      if (ok) begin mCare[idx] = care; mVal[idx] = val & care; end
    end
    @(negedge clk);
    wrEn = 1'b0; srchEn = 1'b0;
  endtask

  task automatic write(input int idx, input bit ok,
                       input logic [KEY_W-1:0] val, input logic [KEY_W-1:0] care);
    cycle(1'b1, idx, ok, val, care, 1'b0, '0, "");
  endtask

  task automatic search(input logic [KEY_W-1:0] key, input string tag);
    cycle(1'b0, 0, 1'b0, '0, '0, 1'b1, key, tag);
  endtask

  // monitor: pop one expected item for each valid result
  always @(negedge clk) begin
    if (rst_n && resultValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2", "unexpected resultValid", 32'd1, 32'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(hitVec == e.vec, e.tag, "hitVec", 32'(hitVec), 32'(e.vec));
        check(hitAny == e.any, e.tag, "hitAny", 32'(hitAny), 32'(e.any));
        check(hitIdx == e.idx, e.tag, "hitIdx", 32'(hitIdx), 32'(e.idx));
        lastExp = e;
      end
    end
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin mVal[i] = '0; mCare[i] = '0; mOk[i] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(hitVec == '0 && !hitAny && hitIdx == '0, "R1", "outputs in reset",
          {hitVec, hitAny, 8'(hitIdx)}, 32'd0);
    check(!resultValid, "R1", "resultValid in reset", 32'(resultValid), 32'd0);
    rst_n = 1'b1;
    search(8'h00, "R1");
    search(8'hFF, "R9");

    // pattern 10XX0 in the low five bits, upper bits compared
    write(2, 1'b1, 8'b000_10000, 8'b111_11001);
    search(8'b000_10000, "R3");
    search(8'b000_10010, "R3");
    search(8'b000_10100, "R3");
    search(8'b000_10110, "R3");
    search(8'b000_10001, "R4");
    search(8'b000_11000, "R4");
    search(8'b000_00000, "R4");
    search(8'b100_10000, "R4");

    // exact entry and full wildcard entry
    write(0, 1'b1, 8'h3C, 8'hFF);
    search(8'h3C, "R4");
    search(8'h3D, "R4");
    write(5, 1'b1, 8'h00, 8'h00);
    search(8'b000_10010, "R5");
    search(8'h3C, "R6");
    search(8'hFF, "R6");

    // hold while idle
    repeat (3) @(negedge clk);
    check(!resultValid, "R2", "resultValid idle", 32'(resultValid), 32'd0);
    check(hitVec == lastExp.vec && hitIdx == lastExp.idx && hitAny == lastExp.any,
          "R10", "held hitVec", 32'(hitVec), 32'(lastExp.vec));

    // invalidate the wildcard entry
    write(5, 1'b0, 8'h00, 8'h00);
    search(8'hFF, "R7");
    search(8'h3C, "R7");

    // ones under a zero care mask are cleared
    write(3, 1'b1, 8'hFF, 8'h0F);
    search(8'h0F, "R11");
    search(8'hAF, "R11");

    // write and search together
    cycle(1'b1, 7, 1'b1, 8'hAA, 8'hFF, 1'b1, 8'hAA, "R8");
    search(8'hAA, "R8");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2", "results outstanding", 32'(expQ.size()), 32'd0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R2", "watchdog expired", 32'd1, 32'd0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule